// File: doc/BRIEF.md
# Paired-Single Cross-Half Multiplier

This unit takes two 64-bit words. Each word packs two IEEE-754 single-precision numbers: bits 63:32 hold the high half and bits 31:0 hold the low half. Each word is reduced by multiplying its own two halves together. The product of the halves of the first word, `op_a`, becomes the high half of the 64-bit result. The product of the halves of the second word, `op_b`, becomes the low half. Each lane rounds its product to single precision on its own, using the rounding mode given with the operation. The exception flags of the two lanes are ORed into a single flag vector.

Operations enter through a valid/ready handshake. The result and the flags are registered and appear one cycle after the operation is accepted. They stay on the output until the consumer takes them. Subnormal operands are treated as zero, and results that would be subnormal are flushed to zero. This keeps each lane a single combinational multiply-and-round path.

Top module: `ps_rmul_unit`

## Requirements
- R1: `out_result[63:32]` is the product `op_a[63:32] × op_a[31:0]` and `out_result[31:0]` is the product `op_b[63:32] × op_b[31:0]`, all values in single-precision format.
- R2: Each lane rounds on its own according to `rnd_mode`: 0 round to nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward −infinity. Flag bit 0 (inexact) is set whenever the exact product was not representable.
- R3: If a rounded product's biased exponent reaches 255, the lane produces infinity or the largest finite magnitude, with the product's sign. Infinity is produced in mode 0, in mode 2 for a positive product and in mode 3 for a negative product. The lane raises overflow (bit 2) and inexact (bit 0).
- R4: An operand with exponent field 0 is taken as a zero of its sign. If a product's biased exponent is below 1 before rounding, the lane gives a zero of the product's sign and raises underflow (bit 1) and inexact (bit 0).
- R5: Zero × infinity, and any NaN operand, give the quiet NaN 0x7FC00000. Invalid (bit 4) is raised for zero × infinity and for a signaling NaN (fraction bit 22 clear). A quiet NaN operand raises no flag.
- R6: Infinity times a nonzero finite value gives infinity with the XOR of the operand signs. Zero times a finite value gives a zero with that sign. Neither raises a flag.
- R7: `out_flags` is the bitwise OR of the two lanes' flags, laid out {invalid[4], divide-by-zero[3], overflow[2], underflow[1], inexact[0]}. Bit 3 is always 0.
- R8: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 after that edge, with that operation's result. `in_ready` is 0 while an unconsumed result is held and `out_ready` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_flags` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| op_a | input | 64 | Pair reduced into the high result half |
| op_b | input | 64 | Pair reduced into the low result half |
| rnd_mode | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 −inf) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | {high product, low product} |
| out_flags | output | 5 | {invalid, div0, overflow, underflow, inexact} |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Lane order.** A design that swaps which word feeds which half, or that multiplies lane by lane across the two words, gives wrong results on every operand pair.
- **Rounding.** Exact ties and near-ties are run in all four modes. Wrong tie handling or a reversed directed mode moves the last fraction bit by one.
- **Overflow.** Overflow is run in all four modes with both signs. A wrong choice between infinity and the largest finite value shows up here.
- **Underflow and subnormals.** Products at the bottom of the range and subnormal operands would leak nonzero or subnormal encodings if the flush-to-zero were missing.
- **NaN and special operands.** Signaling NaNs, quiet NaNs and zero × infinity check that the canonical quiet NaN is produced and that invalid is raised only where required. One case mixes lanes to show that the flags of both lanes are combined.
- **Back-pressure.** A stalled consumer must neither lose the held result nor let a waiting operation overwrite it.

// File: rtl/ps_rmul_pkg.sv
package ps_rmul_pkg;

  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int WEXP_W  = EXP_W + 2;
  localparam int FLAG_W  = 5;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL = (1 << EXP_W) - 1;

  localparam int FL_INV = 4;
  localparam int FL_DZ  = 3;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 1;
  localparam int FL_INX = 0;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  // Unrounded lane product, or a finished special-case answer.
  typedef struct packed {
    logic                     sign;
    logic                     special;
    logic [WORD_W-1:0]        sp_word;
    logic [FLAG_W-1:0]        sp_flags;
    logic signed [WEXP_W-1:0] exp;
    logic [MANT_W-1:0]        mant;
    logic                     rbit;
    logic                     sticky;
  } lane_mid_t;

endpackage

// File: rtl/ps_lane_mult.sv
module ps_lane_mult
  import ps_rmul_pkg::*;
(
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  output lane_mid_t         mid
);

  logic [EXP_W-1:0]  ex, ey;
  logic [FRAC_W-1:0] fx, fy;
  logic x_zero, y_zero, x_inf, y_inf, x_nan, y_nan, x_snan, y_snan;
  logic [PROD_W-1:0] prod, norm;
  logic              top;
  logic              sgn;

  assign ex = x[WORD_W-2 -: EXP_W];
  assign ey = y[WORD_W-2 -: EXP_W];
  assign fx = x[FRAC_W-1:0];
  assign fy = y[FRAC_W-1:0];

  // Subnormals are flushed: a zero exponent field means zero.
  assign x_zero = (ex == '0);
  assign y_zero = (ey == '0);
  assign x_inf  = (ex == '1) && (fx == '0);
  assign y_inf  = (ey == '1) && (fy == '0);
  assign x_nan  = (ex == '1) && (fx != '0);
  assign y_nan  = (ey == '1) && (fy != '0);
  assign x_snan = x_nan && !fx[FRAC_W-1];
  assign y_snan = y_nan && !fy[FRAC_W-1];
  assign sgn    = x[WORD_W-1] ^ y[WORD_W-1];

  assign prod = PROD_W'({1'b1, fx}) * PROD_W'({1'b1, fy});
  assign top  = prod[PROD_W-1];
  assign norm = top ? prod : (prod << 1);

  always_comb begin
    mid          = '0;
    mid.sign     = sgn;
    mid.exp      = WEXP_W'(ex) + WEXP_W'(ey) - WEXP_W'(BIAS) + WEXP_W'(top);
    mid.mant     = norm[PROD_W-1 -: MANT_W];
    mid.rbit     = norm[PROD_W-1-MANT_W];
    mid.sticky   = |norm[PROD_W-2-MANT_W:0];
    if (x_nan || y_nan) begin
      mid.special          = 1'b1;
      mid.sp_word          = QNAN_WORD;
      mid.sp_flags[FL_INV] = x_snan || y_snan;
    end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
      mid.special          = 1'b1;
      mid.sp_word          = QNAN_WORD;
      mid.sp_flags[FL_INV] = 1'b1;
    end else if (x_inf || y_inf) begin
      mid.special = 1'b1;
      mid.sp_word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (x_zero || y_zero) begin
      mid.special = 1'b1;
      mid.sp_word = {sgn, {(WORD_W-1){1'b0}}};
    end
  end

endmodule

// File: rtl/ps_lane_round.sv
module ps_lane_round
  import ps_rmul_pkg::*;
(
  input  lane_mid_t         mid,
  input  rmode_e            mode,
  output logic [WORD_W-1:0] word,
  output logic [FLAG_W-1:0] flags
);

  logic                     lost;
  logic                     inc;
  logic [MANT_W:0]          sum;
  logic                     carry;
  logic [FRAC_W-1:0]        frac_r;
  logic signed [WEXP_W-1:0] exp_r;
  logic                     to_inf;

  assign lost = mid.rbit | mid.sticky;

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = mid.rbit & (mid.sticky | mid.mant[0]);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = lost & ~mid.sign;
      RM_NEG:  inc = lost & mid.sign;
      default: inc = 1'b0;
    endcase
  end

  assign sum    = {1'b0, mid.mant} + (MANT_W+1)'(inc);
  assign carry  = sum[MANT_W];
  assign frac_r = carry ? sum[MANT_W-1:1] : sum[FRAC_W-1:0];
  assign exp_r  = mid.exp + WEXP_W'(carry);
  assign to_inf = (mode == RM_NEAR) || ((mode == RM_POS) && !mid.sign) ||
                  ((mode == RM_NEG) && mid.sign);

  always_comb begin
    word  = '0;
    flags = '0;
    if (mid.special) begin
      word  = mid.sp_word;
      flags = mid.sp_flags;
    end else if (mid.exp < 1) begin
      word          = {mid.sign, {(WORD_W-1){1'b0}}};
      flags[FL_UNF] = 1'b1;
      flags[FL_INX] = 1'b1;
    end else if (exp_r >= EXP_ALL) begin
      word          = to_inf ? {mid.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                             : {mid.sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      flags[FL_OVF] = 1'b1;
      flags[FL_INX] = 1'b1;
    end else begin
      word          = {mid.sign, exp_r[EXP_W-1:0], frac_r};
      flags[FL_INX] = lost;
    end
  end

endmodule

// File: rtl/ps_rmul_unit.sv
module ps_rmul_unit
  import ps_rmul_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*WORD_W-1:0]   op_a,
  input  logic [2*WORD_W-1:0]   op_b,
  input  logic [1:0]            rnd_mode,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*WORD_W-1:0]   out_result,
  output logic [FLAG_W-1:0]     out_flags
);

  localparam int LANES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Lanes: the top lane reduces op_a, lane 0 reduces op_b.
  logic [LANES-1:0][WORD_W-1:0] lane_word;
  logic [LANES-1:0][FLAG_W-1:0] lane_flags;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2*WORD_W-1:0] src;
    lane_mid_t           mid;
    assign src = (g == LANES - 1) ? op_a : op_b;
    ps_lane_mult u_mult (
      .x   (src[2*WORD_W-1:WORD_W]),
      .y   (src[WORD_W-1:0]),
      .mid (mid)
    );
    ps_lane_round u_round (
      .mid   (mid),
      .mode  (rmode_e'(rnd_mode)),
      .word  (lane_word[g]),
      .flags (lane_flags[g])
    );
  end

  logic [FLAG_W-1:0] flags_all;
  always_comb begin
    flags_all = '0;
    for (int i = 0; i < LANES; i++) flags_all |= lane_flags[i];
  end

  // Next state
  logic accept, valid_nxt;
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign valid_nxt = accept || (out_valid && !out_ready);

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_valid <= 1'b0;
    else            out_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_result <= '0;
      out_flags  <= '0;
    end else if (accept) begin
      out_result <= lane_word;
      out_flags  <= flags_all;
    end
  end

  logic [WORD_W-1:0] res_hi;
  assign res_hi = out_result[2*WORD_W-1:WORD_W];

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags))); // R9
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_flags[FL_OVF]) |-> out_flags[FL_INX]); // R3
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_flags[FL_UNF]) |-> out_flags[FL_INX]); // R4
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (res_hi[WORD_W-2 -: EXP_W] == '1) && (res_hi[FRAC_W-1:0] != '0))
      |-> (res_hi == QNAN_WORD)); // R5

endmodule

// File: tb/tb_ps_rmul_unit.sv
module tb_ps_rmul_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] op_a, op_b, out_result;
  logic [1:0]  rnd_mode;
  logic [4:0]  out_flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  bit [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  ps_rmul_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------- real-number reference ----------
  function automatic real fp_val(input bit [31:0] w);
    real m;
    int  e;
    if (w[30:23] == 0) return 0.0;
    m = 1.0 + real'(w[22:0]) / 8388608.0;
    e = int'(w[30:23]) - 127;
    while (e > 0) begin m = m * 2.0; e--; end
    while (e < 0) begin m = m / 2.0; e++; end
    return w[31] ? -m : m;
  endfunction

  task automatic ref_mul(input bit [31:0] x, input bit [31:0] y, input bit [1:0] m,
                         output bit [31:0] w, output bit [4:0] fl);
    real v, mag, sc, rem;
    int  e, be, fr;
    bit  s, up, big;
    v   = fp_val(x) * fp_val(y);
    s   = x[31] ^ y[31];
    mag = (v < 0.0) ? -v : v;
    fl  = 5'b0;
    if (mag == 0.0) begin w = {s, 31'b0}; return; end
    e = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0)  begin mag = mag * 2.0; e--; end
    be = e + 127;
    if (be < 1) begin w = {s, 31'b0}; fl = 5'b00011; return; end
    sc  = (mag - 1.0) * 8388608.0;
    fr  = $rtoi(sc);
    rem = sc - real'(fr);
    case (m)
      2'd0: up = (rem > 0.5) || ((rem == 0.5) && fr[0]);
      2'd1: up = 1'b0;
      2'd2: up = (rem > 0.0) && !s;
      default: up = (rem > 0.0) && s;
    endcase
    if (up) fr++;
    if (fr == 8388608) begin fr = 0; be++; end
    if (be >= 255) begin
      big = (m == 2'd0) || ((m == 2'd2) && !s) || ((m == 2'd3) && s);
      w   = big ? {s, 8'hFF, 23'h0} : {s, 8'hFE, 23'h7FFFFF};
      fl  = 5'b00101;
    end else begin
      w  = {s, be[7:0], fr[22:0]};
      fl = (rem > 0.0) ? 5'b00001 : 5'b00000;
    end
  endtask

  task automatic next_rand(output bit [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic rand_normal(output bit [31:0] w);
    bit [31:0] r1, r2;
    next_rand(r1);
    next_rand(r2);
    w = {r1[31], 8'(64 + (r1[30:23] % 127)), r2[22:0]};
  endtask

  // One operation with the consumer ready; result sampled the cycle after acceptance.
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                        output logic [63:0] r, output logic [4:0] f);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; rnd_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid after accept", 64'(out_valid), 64'd1);
    r = out_result;
    f = out_flags;
  endtask

  // ---------- scenarios ----------
  task automatic t_reset;
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_lane_order;
    logic [63:0] r; logic [4:0] f;
    // high: 1.5*2.0=3.0 ; low: -3.0*0.5=-1.5
    run_op({32'h3FC00000, 32'h40000000}, {32'hC0400000, 32'h3F000000}, 2'd0, r, f);
    chk("R1 lane order result", r, {32'h40400000, 32'hBFC00000});
    chk("R1 exact flags", 64'(f), 64'd0);
    run_op({32'hC0400000, 32'h3F000000}, {32'h3FC00000, 32'h40000000}, 2'd1, r, f);
    chk("R1 swapped words", r, {32'hBFC00000, 32'h40400000});
  endtask

  task automatic t_round_ties;
    logic [63:0] r; logic [4:0] f;
    // (1+u)*1.5: tie on odd lsb ; (1+3u)*1.5: tie on even lsb
    logic [63:0] a = {32'h3F800001, 32'h3FC00000};
    logic [63:0] b = {32'h3F800003, 32'h3FC00000};
    run_op(a, b, 2'd0, r, f);
    chk("R2 nearest-even ties", r, {32'h3FC00002, 32'h3FC00004});
    chk("R2 inexact flag", 64'(f), 64'd1);
    run_op(a, b, 2'd1, r, f);
    chk("R2 toward zero", r, {32'h3FC00001, 32'h3FC00004});
    run_op(a, b, 2'd2, r, f);
    chk("R2 toward +inf", r, {32'h3FC00002, 32'h3FC00005});
    run_op({32'hBF800001, 32'h3FC00000}, b, 2'd3, r, f);
    chk("R2 toward -inf", r, {32'hBFC00002, 32'h3FC00004});
  endtask

  task automatic t_random;
    logic [63:0] r; logic [4:0] f;
    bit [31:0] a1, a0, b1, b0, eh, el;
    bit [4:0]  fh, fl;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 60; k++) begin
        rand_normal(a1); rand_normal(a0); rand_normal(b1); rand_normal(b0);
        ref_mul(a1, a0, 2'(m), eh, fh);
        ref_mul(b1, b0, 2'(m), el, fl);
        run_op({a1, a0}, {b1, b0}, 2'(m), r, f);
        chk("R1 R2 random product", r, {eh, el});
        chk("R2 R7 random flags", 64'(f), 64'(fh | fl));
      end
    end
  endtask

  task automatic t_overflow;
    logic [63:0] r; logic [4:0] f;
    logic [63:0] a = {32'h7F7FFFFF, 32'h40000000};
    logic [63:0] b = {32'hFF7FFFFF, 32'h40000000};
    run_op(a, b, 2'd0, r, f);
    chk("R3 overflow nearest", r, {32'h7F800000, 32'hFF800000});
    chk("R3 overflow flags", 64'(f), 64'b00101);
    run_op(a, b, 2'd1, r, f);
    chk("R3 overflow toward zero", r, {32'h7F7FFFFF, 32'hFF7FFFFF});
    run_op(a, b, 2'd2, r, f);
    chk("R3 overflow toward +inf", r, {32'h7F800000, 32'hFF7FFFFF});
    run_op(a, b, 2'd3, r, f);
    chk("R3 overflow toward -inf", r, {32'h7F7FFFFF, 32'hFF800000});
  endtask

  task automatic t_underflow;
    logic [63:0] r; logic [4:0] f;
    // min normal * -0.5 -> flushed ; subnormal * 2.0 -> zero, no flag
    run_op({32'h00800000, 32'hBF000000}, {32'h3F800000, 32'h3F800000}, 2'd0, r, f);
    chk("R4 underflow flush", r, {32'h80000000, 32'h3F800000});
    chk("R4 underflow flags", 64'(f), 64'b00011);
    run_op({32'h00000001, 32'h40000000}, {32'h3F800000, 32'h3F800000}, 2'd0, r, f);
    chk("R4 subnormal operand as zero", r, {32'h00000000, 32'h3F800000});
    chk("R4 subnormal no flags", 64'(f), 64'd0);
  endtask

  task automatic t_specials;
    logic [63:0] r; logic [4:0] f;
    run_op({32'h00000000, 32'h7F800000}, {32'h3F800000, 32'h3F800000}, 2'd0, r, f);
    chk("R5 zero times inf", r, {32'h7FC00000, 32'h3F800000});
    chk("R5 zero times inf invalid", 64'(f), 64'b10000);
    run_op({32'h00400000, 32'hFF800000}, {32'h3F800000, 32'h3F800000}, 2'd0, r, f);
    chk("R4 R5 subnormal times inf", r, {32'h7FC00000, 32'h3F800000});
    run_op({32'h7F800001, 32'h3F800000}, {32'h3F800000, 32'h3F800000}, 2'd0, r, f);
    chk("R5 signaling NaN", r, {32'h7FC00000, 32'h3F800000});
    chk("R5 signaling NaN invalid", 64'(f), 64'b10000);
    run_op({32'h3F800000, 32'h3F800000}, {32'hFFC00000, 32'h40000000}, 2'd0, r, f);
    chk("R5 quiet NaN", r, {32'h3F800000, 32'h7FC00000});
    chk("R5 quiet NaN no flag", 64'(f), 64'd0);
    run_op({32'hFF800000, 32'h40000000}, {32'h80000000, 32'h3F800000}, 2'd0, r, f);
    chk("R6 inf and signed zero", r, {32'hFF800000, 32'h80000000});
    chk("R6 no flags", 64'(f), 64'd0);
  endtask

  task automatic t_flag_merge;
    logic [63:0] r; logic [4:0] f;
    run_op({32'h7F7FFFFF, 32'h40000000}, {32'h00000000, 32'h7F800000}, 2'd0, r, f);
    chk("R7 merged result", r, {32'h7F800000, 32'h7FC00000});
    chk("R7 merged flags", 64'(f), 64'b10101);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; rnd_mode = 2'd0;
    op_a = {32'h3FC00000, 32'h40000000}; op_b = {32'h3F800000, 32'h40400000};
    @(negedge clk);
    chk("R8 valid while stalled", 64'(out_valid), 64'd1);
    chk("R8 in_ready low while stalled", 64'(in_ready), 64'd0);
    op_a = {32'h40000000, 32'h40000000}; op_b = {32'h40800000, 32'h3F000000};
    @(negedge clk);
    @(negedge clk);
    chk("R9 result held", out_result, {32'h40400000, 32'h40400000});
    chk("R9 valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next operation after release", out_result, {32'h40800000, 32'h40000000});
    @(negedge clk);
    chk("R8 valid drops when consumed", 64'(out_valid), 64'd0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    op_a = '0; op_b = '0; rnd_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lane_order();
    t_round_ties();
    t_overflow();
    t_underflow();
    t_specials();
    t_flag_merge();
    t_backpressure();
    t_random();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule